// File: doc/BRIEF.md
# Cascaded Watchdog Timeout Controller

The block is a watchdog built from two chained down-counters. A prescaler divides the system clock into a slow tick. Each tick steps the first counter. Each time the first counter finishes a full period, the second counter steps once. The watchdog times out when the second counter's last period ends. From then on, an active-low reset output stays asserted until software refreshes the watchdog or disables it.

Software sets the two reload values through a small configuration port, then pulses a refresh strobe at regular intervals. One first-counter period before the timeout, the block raises a warning interrupt and drives an active-low reminder bit in a 4-bit status word. An interrupt handler can therefore refresh the watchdog in time. A write strobe on the status address clears the pending interrupt. The same status word also passes through a temperature-good input and two isolated inputs. While the watchdog is enabled, a square-wave indicator output toggles continuously.

Top module: `wdt_cascade`

## Requirements
- R1: Once reset is released with the watchdog disabled, the outputs settle to wdt_rst_no = 1, irq_o = 0, status_o[0] = 1 and sq_o = 0.
- R2: Timeout timing and reset output:
  - Call the reload values L0 and L1 and the prescaler ratio DIV.
  - Timing starts at the first rising edge that sees en_i high, or at the edge that samples kick_i.
  - wdt_rst_no stays high for DIV*L0*L1 - 1 further edges.
  - wdt_rst_no goes low after edge DIV*L0*L1.
- R3: Once low, wdt_rst_no stays low for as long as en_i is high and kick_i is low.
- R4: Early warning:
  - When L1 >= 2, irq_o rises and status_o[0] (active-low reminder) falls after edge DIV*L0*(L1-1). This is one first-counter period before the timeout.
  - When L1 = 1, no warning is raised before the timeout.
- R5: A stat_wr_i pulse clears irq_o on the next edge. If a warning occurs on the same edge, the warning wins and irq_o stays high.
- R6: Refresh:
  - A kick_i pulse reloads both counters and restarts the prescaler, so the R2 timing counts again from that edge.
  - It releases wdt_rst_no and returns status_o[0] to 1.
  - It leaves irq_o unchanged.
- R7: While en_i is low:
  - Both counters are held at their reload values.
  - wdt_rst_no is high, irq_o is low, status_o[0] is 1 and sq_o is low.
  - Re-enabling restarts the R2 timing from the beginning.
- R8: Status pass-through bits: status_o[1] = temp_ok_i, status_o[2] = iso_i[0] and status_o[3] = iso_i[1], with no delay.
- R9: Square-wave indicator:
  - While enabled, sq_o toggles every SQ_HALF clock edges.
  - The first rise of sq_o follows edge SQ_HALF after enable.
- R10: Configuration writes:
  - A cfg_we_i pulse with cfg_sel_i = 0 writes L0; with cfg_sel_i = 1 it writes L1.
  - A written value of 0 is stored as 1.
  - A new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Watchdog enable |
| kick_i | input | 1 | Refresh strobe, reloads both counters |
| cfg_we_i | input | 1 | Reload value write strobe |
| cfg_sel_i | input | 1 | 0 selects L0, 1 selects L1 |
| cfg_data_i | input | CNT_W | Reload value to write |
| stat_wr_i | input | 1 | Status write strobe, clears interrupt |
| temp_ok_i | input | 1 | Temperature-good input, mirrored to status bit 1 |
| iso_i | input | 2 | Isolated inputs, mirrored to status bits 2 and 3 |
| status_o | output | 4 | Status word |
| irq_o | output | 1 | Early-warning interrupt, level |
| wdt_rst_no | output | 1 | Active-low timeout reset |
| sq_o | output | 1 | Square-wave indicator while enabled |

## Verification
The cascade is tried with three reload pairs: 3/3, a zero write stored as 1 paired with 2, and 2/1. Together they show whether the two counters multiply into the timeout period, whether the zero write is clamped to 1, and whether the warning is suppressed when the second counter has a single period. Each timeout and each warning edge is sampled one edge early and on time, so an off-by-one in the prescaler or at either counter's terminal count shows up. The refresh-after-warning and disable-midway patterns show whether timing restarts at the refresh or enable edge, or carries on from stale state. A status write placed on the very edge of a warning shows which of the two takes priority.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned STAT_W = 4;

  typedef struct packed {
    logic iso_b;
    logic iso_a;
    logic temp_ok;
    logic remind_n;
  } wdt_status_t;
endpackage

// File: rtl/wdt_div.sv
// Free-running divider: one-cycle tick every DIV enabled clocks.
module wdt_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_stage.sv
// One cascade stage: counts rld_i steps per period, tc on the last step.
module wdt_stage #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign tc_o  = step_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ONE;
    end else if (load_i) begin
      cnt_q <= rld_i;
    end else if (zero_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= tc_o ? rld_i : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_irq.sv
// Warning interrupt and active-low refresh reminder.
module wdt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic kick_i,
  input  logic warn_i,
  input  logic stat_wr_i,
  output logic irq_o,
  output logic remind_n_o
);
  logic irq_q;
  logic remind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (!en_i) begin
      irq_q <= 1'b0;
    end else if (warn_i) begin
      irq_q <= 1'b1;
    end else if (stat_wr_i) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remind_q <= 1'b0;
    end else if (!en_i || kick_i) begin
      remind_q <= 1'b0;
    end else if (warn_i) begin
      remind_q <= 1'b1;
    end
  end

  assign irq_o      = irq_q;
  assign remind_n_o = !remind_q;
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DIV     = 16,
  parameter int unsigned SQ_HALF = 8,
  parameter int unsigned DEF_L0  = 4,
  parameter int unsigned DEF_L1  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              kick_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CNT_W-1:0]  cfg_data_i,
  input  logic              stat_wr_i,
  input  logic              temp_ok_i,
  input  logic [1:0]        iso_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              wdt_rst_no,
  output logic              sq_o
);
  localparam int unsigned NSTG = 2;
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rld_q [NSTG];
  logic [CNT_W-1:0] cnt   [NSTG];
  logic [NSTG-1:0]  step;
  logic [NSTG-1:0]  tc;

  logic load, run, tick, timeout_ev, warn_ev, expired_q;
  logic sq_tick, sq_q, remind_n;
  wdt_status_t stat;

  // reload registers; zero clamps to one
  for (genvar g = 0; g < NSTG; g++) begin : g_rld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rld_q[g] <= (g == 0) ? CNT_W'(DEF_L0) : CNT_W'(DEF_L1);
      end else if (cfg_we_i && (cfg_sel_i == 1'(g))) begin
        rld_q[g] <= (cfg_data_i == '0) ? CNT_W'(1) : cfg_data_i;
      end
    end
  end

  assign load = !en_i || kick_i;
  assign run  = en_i && !kick_i && !expired_q;

  wdt_div #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (load),
    .tick_o (tick)
  );

  // stage g steps on terminal count of stage g-1
  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    if (g == 0) begin : g_first
      assign step[g] = tick;
    end else begin : g_next
      assign step[g] = tc[g-1];
    end
    wdt_stage #(.CNT_W(CNT_W)) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .step_i (step[g]),
      .zero_i (timeout_ev),
      .rld_i  (rld_q[g]),
      .cnt_o  (cnt[g]),
      .tc_o   (tc[g])
    );
  end

  assign timeout_ev = tc[NSTG-1];
  assign warn_ev    = tc[0] && (cnt[NSTG-1] == TWO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expired_q <= 1'b0;
    end else if (load) begin
      expired_q <= 1'b0;
    end else if (timeout_ev) begin
      expired_q <= 1'b1;
    end
  end

  wdt_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .kick_i     (kick_i),
    .warn_i     (warn_ev),
    .stat_wr_i  (stat_wr_i),
    .irq_o      (irq_o),
    .remind_n_o (remind_n)
  );

  wdt_div #(.DIV(SQ_HALF)) u_sq_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .clr_i  (!en_i),
    .tick_o (sq_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q <= 1'b0;
    end else if (!en_i) begin
      sq_q <= 1'b0;
    end else if (sq_tick) begin
      sq_q <= !sq_q;
    end
  end

  always_comb begin
    stat.remind_n = remind_n;
    stat.temp_ok  = temp_ok_i;
    stat.iso_a    = iso_i[0];
    stat.iso_b    = iso_i[1];
  end

  assign status_o   = stat;
  assign wdt_rst_no = !expired_q;
  assign sq_o       = sq_q;
endmodule

// File: rtl/wdt_cascade_chk.sv
module wdt_cascade_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       kick_i,
  input logic       stat_wr_i,
  input logic       warn_ev,
  input logic [3:0] status_o,
  input logic       irq_o,
  input logic       wdt_rst_no,
  input logic       sq_o
);
  assert_rst_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !kick_i && !wdt_rst_no |=> !wdt_rst_no);

  assert_warn_remind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !status_o[0]);

  assert_irq_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stat_wr_i && !warn_ev |=> !irq_o);

  assert_refresh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && kick_i |=> wdt_rst_no && status_o[0]);

  assert_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> wdt_rst_no && !irq_o && !sq_o && status_o[0]);
endmodule

bind wdt_cascade wdt_cascade_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .kick_i     (kick_i),
  .stat_wr_i  (stat_wr_i),
  .warn_ev    (warn_ev),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .wdt_rst_no (wdt_rst_no),
  .sq_o       (sq_o)
);

// File: tb/wdt_cascade_tb.sv
module wdt_cascade_tb;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned DIV = 16;
  localparam int unsigned SQ_HALF = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, kick_i = 1'b0, cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [CNT_W-1:0] cfg_data_i = '0;
  logic stat_wr_i = 1'b0, temp_ok_i = 1'b0;
  logic [1:0] iso_i = 2'b00;
  logic [3:0] status_o;
  logic irq_o, wdt_rst_no, sq_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = !clk_i;

  wdt_cascade #(.CNT_W(CNT_W), .DIV(DIV), .SQ_HALF(SQ_HALF)) u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cfg(input logic sel, input logic [CNT_W-1:0] v);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = v;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic start(input logic [CNT_W-1:0] l0, input logic [CNT_W-1:0] l1);
    en_i = 1'b0;
    step(1);
    cfg(1'b0, l0);
    cfg(1'b1, l1);
    step(1);
    en_i = 1'b1;
  endtask

  task automatic pulse_kick();
    kick_i = 1'b1; step(1); kick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rst_n", 8'(wdt_rst_no), 8'd1);
    chk("R1 irq", 8'(irq_o), 8'd0);
    chk("R1 remind", 8'(status_o[0]), 8'd1);
    chk("R1 sq", 8'(sq_o), 8'd0);
  endtask

  task automatic t_timeout();
    start(8'd3, 8'd3);
    step(95);
    chk("R4 irq early", 8'(irq_o), 8'd0);
    chk("R4 remind early", 8'(status_o[0]), 8'd1);
    step(1);
    chk("R4 irq at warn", 8'(irq_o), 8'd1);
    chk("R4 remind at warn", 8'(status_o[0]), 8'd0);
    step(47);
    chk("R2 before timeout", 8'(wdt_rst_no), 8'd1);
    step(1);
    chk("R2 at timeout", 8'(wdt_rst_no), 8'd0);
    step(200);
    chk("R3 reset held", 8'(wdt_rst_no), 8'd0);
    stat_wr_i = 1'b1; step(1); stat_wr_i = 1'b0;
    chk("R5 irq cleared", 8'(irq_o), 8'd0);
    chk("R3 held after stat write", 8'(wdt_rst_no), 8'd0);
    pulse_kick();
    chk("R6 reset released", 8'(wdt_rst_no), 8'd1);
    chk("R6 reminder cleared", 8'(status_o[0]), 8'd1);
  endtask

  task automatic t_kick();
    start(8'd3, 8'd3);
    step(100);
    pulse_kick();
    chk("R6 irq kept", 8'(irq_o), 8'd1);
    chk("R6 reminder cleared", 8'(status_o[0]), 8'd1);
    step(143);
    chk("R6 no timeout before restart window", 8'(wdt_rst_no), 8'd1);
    step(1);
    chk("R6 timeout after kick window", 8'(wdt_rst_no), 8'd0);
    en_i = 1'b0; step(1);
    chk("R7 rst released", 8'(wdt_rst_no), 8'd1);
    chk("R7 irq cleared", 8'(irq_o), 8'd0);
    chk("R7 reminder", 8'(status_o[0]), 8'd1);
    chk("R7 sq low", 8'(sq_o), 8'd0);
  endtask

  task automatic t_disable_restart();
    start(8'd3, 8'd3);
    step(120);
    en_i = 1'b0; step(30);
    chk("R7 held while disabled", 8'(wdt_rst_no), 8'd1);
    en_i = 1'b1;
    step(143);
    chk("R7 restart before timeout", 8'(wdt_rst_no), 8'd1);
    step(1);
    chk("R7 restart timeout", 8'(wdt_rst_no), 8'd0);
  endtask

  task automatic t_priority();
    start(8'd3, 8'd3);
    step(95);
    stat_wr_i = 1'b1; step(1); stat_wr_i = 1'b0;
    chk("R5 warn wins over clear", 8'(irq_o), 8'd1);
    stat_wr_i = 1'b1; step(1); stat_wr_i = 1'b0;
    chk("R5 later clear", 8'(irq_o), 8'd0);
  endtask

  task automatic t_cfg();
    start(8'd0, 8'd2);
    step(15);
    chk("R10 zero clamp warn early", 8'(irq_o), 8'd0);
    step(1);
    chk("R10 zero clamp warn", 8'(irq_o), 8'd1);
    step(15);
    chk("R10 before timeout", 8'(wdt_rst_no), 8'd1);
    step(1);
    chk("R10 timeout at 32", 8'(wdt_rst_no), 8'd0);
    start(8'd2, 8'd1);
    step(31);
    chk("R4 no warn when L1=1", 8'(irq_o), 8'd0);
    chk("R2 L1=1 before timeout", 8'(wdt_rst_no), 8'd1);
    step(1);
    chk("R2 L1=1 timeout", 8'(wdt_rst_no), 8'd0);
    chk("R4 no warn at timeout", 8'(irq_o), 8'd0);
  endtask

  task automatic t_status();
    temp_ok_i = 1'b1; iso_i = 2'b10; #1;
    chk("R8 pattern a", 8'(status_o[3:1]), 8'b101);
    temp_ok_i = 1'b0; iso_i = 2'b01; #1;
    chk("R8 pattern b", 8'(status_o[3:1]), 8'b010);
  endtask

  task automatic t_sq();
    en_i = 1'b0; step(2);
    chk("R9 low when disabled", 8'(sq_o), 8'd0);
    en_i = 1'b1;
    step(SQ_HALF - 1);
    chk("R9 before first toggle", 8'(sq_o), 8'd0);
    step(1);
    chk("R9 first toggle", 8'(sq_o), 8'd1);
    step(SQ_HALF);
    chk("R9 second toggle", 8'(sq_o), 8'd0);
    en_i = 1'b0; step(1);
  endtask

  initial begin
    #25 rst_ni = 1'b1;
    step(2);
    t_reset();
    t_status();
    t_timeout();
    t_kick();
    t_disable_restart();
    t_priority();
    t_cfg();
    t_sq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule